// File: doc/BRIEF.md
# USB PHY Power-Up and Low-Leakage Sequencer

This block is a small hardware sequencer that brings a dual-mode USB PHY out of reset and later places it in a low-leakage state. An init request walks a fixed chain of one-cycle steps. Each step drives a group of control outputs. The chain ends with a timed port-reset pulse, and after that pulse the PHY is ready. An exit request forces the PHY into suspend and sleep, removes the clock enables and powers down both signal paths.

A mode input is sampled when init is accepted. It chooses which path is powered up: the high-speed path (UTMI-style) or the SuperSpeed path (PIPE3-style). Every control field is a separate output, so the block drives the PHY directly with no register access in between. The length of the reset pulse comes from two parameters: the clock frequency in MHz and the hold time in microseconds.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset the outputs read as follows. frame_adj=0, ver_ctl=0, ref_use_pad=1, utmi_clk_sel=0, los_level=0, tx_deemph=0. otg_disable, force_suspend and force_sleep are 0. hs_pwrdn=1 and ss_pwrdn=1. All clock enables are 0, and port_reset, ready, busy and ctl_clear are 0.
- R2: A request is accepted only while busy=0. Init or exit requests raised while busy=1 have no effect on any output. busy is 1 from the cycle after acceptance until the sequence returns to idle.
- R3: After an init is accepted at clock edge e0, ctl_clear is 1 for exactly one cycle, after edge e1. No other output has changed at that point except ready, which is cleared.
- R4: After edge e2, frame_adj=0x20 and ver_ctl=1.
- R5: After edge e3, ref_use_pad=0 and utmi_clk_sel=1, in both modes.
- R6: With mode_ss=0 (high-speed), after edge e4 the outputs read los_level=0x09, tx_deemph=0x1C, otg_disable=1, force_suspend=0, force_sleep=0 and hs_pwrdn=0. ss_pwrdn is unchanged.
- R7: With mode_ss=1 (SuperSpeed), after edge e4 tx_deemph=0x1C and ss_pwrdn=0. los_level, otg_disable, force_suspend, force_sleep and hs_pwrdn keep their previous values.
- R8: After edge e5, ret_enable, ref_ss_en, ssc_en, common_on and port_reset all become 1 together. port_reset stays 1 for exactly CLK_MHZ*HOLD_US cycles (40 with the defaults). After that only port_reset returns to 0.
- R9: ready rises on the same edge on which port_reset falls. Both exit and a newly accepted init clear it.
- R10: One edge after an exit is accepted, otg_disable, force_suspend, force_sleep, hs_pwrdn and ss_pwrdn are all 1. ref_ss_en, ssc_en, common_on and ready are 0. ret_enable is unchanged.
- R11: If init and exit are both requested in the same idle cycle, only the exit is performed. No ctl_clear appears and no port reset is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Request the power-up sequence |
| exit_req | input | 1 | Request the low-leakage state |
| mode_ss | input | 1 | 1 = SuperSpeed path, 0 = high-speed path |
| ctl_clear | output | 1 | One-cycle strobe that clears the PHY control and resume words |
| frame_adj | output | 6 | Frame-length adjust value |
| ver_ctl | output | 1 | Link version-control enable |
| ref_use_pad | output | 1 | Reference taken from the pad |
| utmi_clk_sel | output | 1 | UTMI clock select |
| los_level | output | 5 | Loss-of-signal detector level |
| tx_deemph | output | 5 | TX de-emphasis level |
| otg_disable | output | 1 | OTG block disable |
| force_suspend | output | 1 | Force suspend |
| force_sleep | output | 1 | Force sleep |
| hs_pwrdn | output | 1 | High-speed path powerdown |
| ss_pwrdn | output | 1 | SuperSpeed path powerdown |
| ret_enable | output | 1 | Digital supply out of retention |
| ref_ss_en | output | 1 | SuperSpeed reference clock enable |
| ssc_en | output | 1 | Spread-spectrum enable |
| common_on | output | 1 | Common bias/PLL keep-on |
| port_reset | output | 1 | Port reset pulse |
| ready | output | 1 | PHY released from port reset |
| busy | output | 1 | Sequence in progress |

## Verification
The bench checks each step one edge at a time. A design that merges or reorders steps would show frame_adj, the clock select or the powerdowns changing on the wrong edge. It measures the width of the port-reset pulse, where an off-by-one in the hold counter shows up as 39 or 41 cycles. It chains the two modes behind exits to show that the SuperSpeed path leaves the high-speed fields alone, while the high-speed path clears the force bits set by exit. Finally, it raises requests during the hold and raises both requests together: a design that does not ignore the first would restart or shorten the pulse, and one that favours init would give a reset in the second case.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CLR    = 3'd1,
    S_LINK   = 3'd2,
    S_CLKSRC = 3'd3,
    S_PATH   = 3'd4,
    S_RSTON  = 3'd5,
    S_HOLD   = 3'd6,
    S_EXIT   = 3'd7
  } seq_state_t;

  localparam logic [5:0] FRAME_ADJ_VAL = 6'h20;
  localparam logic [4:0] LOS_LVL_VAL   = 5'h09;
  localparam logic [4:0] DEEMPH_VAL    = 5'h1C;

  // Cycles of port-reset hold; never less than one.
  function automatic int unsigned hold_cycles(input int unsigned mhz, input int unsigned us);
    int unsigned n;
    n = mhz * us;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/usbphy_hold_timer.sv
module usbphy_hold_timer #(
  parameter int unsigned HOLD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= LAST));

endmodule

// File: rtl/usbphy_seq_fsm.sv
module usbphy_seq_fsm
  import usbphy_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic exit_req,
  input  logic mode_ss,
  input  logic timer_done,
  output logic st_clear,
  output logic st_link,
  output logic st_clksrc,
  output logic st_path,
  output logic st_rst_on,
  output logic st_rst_off,
  output logic st_exit,
  output logic mode_q,
  output logic busy
);
  seq_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (exit_req)      nxt = S_EXIT;
        else if (init_req) nxt = S_CLR;
      end
      S_CLR:    nxt = S_LINK;
      S_LINK:   nxt = S_CLKSRC;
      S_CLKSRC: nxt = S_PATH;
      S_PATH:   nxt = S_RSTON;
      S_RSTON:  nxt = S_HOLD;
      S_HOLD:   if (timer_done) nxt = S_IDLE;
      S_EXIT:   nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && init_req && !exit_req) mode_q <= mode_ss;
    end
  end

  assign st_clear   = (state == S_CLR);
  assign st_link    = (state == S_LINK);
  assign st_clksrc  = (state == S_CLKSRC);
  assign st_path    = (state == S_PATH);
  assign st_rst_on  = (state == S_RSTON);
  assign st_rst_off = (state == S_HOLD) && timer_done;
  assign st_exit    = (state == S_EXIT);
  assign busy       = (state != S_IDLE);

  assert_exit_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && init_req && exit_req) |=> (state == S_EXIT));
  assert_hold_ignores_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && !timer_done) |=> (state == S_HOLD));
  assert_steps_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_clear, st_link, st_clksrc, st_path, st_rst_on, st_rst_off, st_exit}));

endmodule

// File: rtl/usbphy_ctl_regs.sv
module usbphy_ctl_regs
  import usbphy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_clear,
  input  logic       st_link,
  input  logic       st_clksrc,
  input  logic       st_path,
  input  logic       st_rst_on,
  input  logic       st_rst_off,
  input  logic       st_exit,
  input  logic       mode_q,
  output logic       ctl_clear,
  output logic [5:0] frame_adj,
  output logic       ver_ctl,
  output logic       ref_use_pad,
  output logic       utmi_clk_sel,
  output logic [4:0] los_level,
  output logic [4:0] tx_deemph,
  output logic       otg_disable,
  output logic       force_suspend,
  output logic       force_sleep,
  output logic       hs_pwrdn,
  output logic       ss_pwrdn,
  output logic       ret_enable,
  output logic       ref_ss_en,
  output logic       ssc_en,
  output logic       common_on,
  output logic       port_reset,
  output logic       ready
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_clear     <= 1'b0;
      frame_adj     <= '0;
      ver_ctl       <= 1'b0;
      ref_use_pad   <= 1'b1;
      utmi_clk_sel  <= 1'b0;
      los_level     <= '0;
      tx_deemph     <= '0;
      otg_disable   <= 1'b0;
      force_suspend <= 1'b0;
      force_sleep   <= 1'b0;
      hs_pwrdn      <= 1'b1;
      ss_pwrdn      <= 1'b1;
      ret_enable    <= 1'b0;
      ref_ss_en     <= 1'b0;
      ssc_en        <= 1'b0;
      common_on     <= 1'b0;
      port_reset    <= 1'b0;
      ready         <= 1'b0;
    end else begin
      ctl_clear <= st_clear;
      if (st_clear) ready <= 1'b0;
      if (st_link) begin
        frame_adj <= FRAME_ADJ_VAL;
        ver_ctl   <= 1'b1;
      end
      if (st_clksrc) begin
        ref_use_pad  <= 1'b0;
        utmi_clk_sel <= 1'b1;
      end
      if (st_path) begin
        tx_deemph <= DEEMPH_VAL;
        if (mode_q) begin
          ss_pwrdn <= 1'b0;
        end else begin
          los_level     <= LOS_LVL_VAL;
          otg_disable   <= 1'b1;
          force_suspend <= 1'b0;
          force_sleep   <= 1'b0;
          hs_pwrdn      <= 1'b0;
        end
      end
      if (st_rst_on) begin
        ret_enable <= 1'b1;
        ref_ss_en  <= 1'b1;
        ssc_en     <= 1'b1;
        common_on  <= 1'b1;
        port_reset <= 1'b1;
      end
      if (st_rst_off) begin
        port_reset <= 1'b0;
        ready      <= 1'b1;
      end
      if (st_exit) begin
        otg_disable   <= 1'b1;
        force_suspend <= 1'b1;
        force_sleep   <= 1'b1;
        ref_ss_en     <= 1'b0;
        ssc_en        <= 1'b0;
        common_on     <= 1'b0;
        hs_pwrdn      <= 1'b1;
        ss_pwrdn      <= 1'b1;
        ready         <= 1'b0;
      end
    end
  end

  assert_clear_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> !ctl_clear);
  assert_rst_with_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_reset) |-> (ret_enable && ref_ss_en && ssc_en && common_on));
  assert_ready_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_reset) |-> ($rose(ready) && common_on));
  assert_hs_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_path && !mode_q) |=> (otg_disable && !force_sleep && !hs_pwrdn));
  assert_ss_path_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_path && mode_q) |=> ($stable(los_level) && $stable(otg_disable) && $stable(hs_pwrdn) && !ss_pwrdn));
  assert_exit_lowleak_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_exit |=> (hs_pwrdn && ss_pwrdn && force_sleep && force_suspend && !common_on && !ready));

endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
  import usbphy_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 4,
  parameter int unsigned HOLD_US = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       exit_req,
  input  logic       mode_ss,
  output logic       ctl_clear,
  output logic [5:0] frame_adj,
  output logic       ver_ctl,
  output logic       ref_use_pad,
  output logic       utmi_clk_sel,
  output logic [4:0] los_level,
  output logic [4:0] tx_deemph,
  output logic       otg_disable,
  output logic       force_suspend,
  output logic       force_sleep,
  output logic       hs_pwrdn,
  output logic       ss_pwrdn,
  output logic       ret_enable,
  output logic       ref_ss_en,
  output logic       ssc_en,
  output logic       common_on,
  output logic       port_reset,
  output logic       ready,
  output logic       busy
);
  localparam int unsigned HOLD = hold_cycles(CLK_MHZ, HOLD_US);

  logic st_clear, st_link, st_clksrc, st_path, st_rst_on, st_rst_off, st_exit;
  logic mode_q, timer_done;

  usbphy_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_req   (init_req),
    .exit_req   (exit_req),
    .mode_ss    (mode_ss),
    .timer_done (timer_done),
    .st_clear   (st_clear),
    .st_link    (st_link),
    .st_clksrc  (st_clksrc),
    .st_path    (st_path),
    .st_rst_on  (st_rst_on),
    .st_rst_off (st_rst_off),
    .st_exit    (st_exit),
    .mode_q     (mode_q),
    .busy       (busy)
  );

  usbphy_hold_timer #(.HOLD(HOLD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (st_rst_on),
    .done  (timer_done)
  );

  usbphy_ctl_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_clear      (st_clear),
    .st_link       (st_link),
    .st_clksrc     (st_clksrc),
    .st_path       (st_path),
    .st_rst_on     (st_rst_on),
    .st_rst_off    (st_rst_off),
    .st_exit       (st_exit),
    .mode_q        (mode_q),
    .ctl_clear     (ctl_clear),
    .frame_adj     (frame_adj),
    .ver_ctl       (ver_ctl),
    .ref_use_pad   (ref_use_pad),
    .utmi_clk_sel  (utmi_clk_sel),
    .los_level     (los_level),
    .tx_deemph     (tx_deemph),
    .otg_disable   (otg_disable),
    .force_suspend (force_suspend),
    .force_sleep   (force_sleep),
    .hs_pwrdn      (hs_pwrdn),
    .ss_pwrdn      (ss_pwrdn),
    .ret_enable    (ret_enable),
    .ref_ss_en     (ref_ss_en),
    .ssc_en        (ssc_en),
    .common_on     (common_on),
    .port_reset    (port_reset),
    .ready         (ready)
  );

  assert_busy_drops_with_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_reset) |-> !busy);

endmodule

// File: tb/sim_usbphy_pwr_seq.sv
module sim_usbphy_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_HOLD   = 4 * 10;

  // {exit_first, mode_ss, los_is_9, otg, susp_and_sleep, hs_pwrdn, ss_pwrdn}
  localparam logic [6:0] VEC [5] = '{
    7'b0_1_0_0_0_1_0,
    7'b0_0_1_1_0_0_0,
    7'b1_1_1_1_1_1_0,
    7'b1_0_1_1_0_0_1,
    7'b0_1_1_1_0_0_0
  };

  logic clk = 0, rst_n = 0, init_req = 0, exit_req = 0, mode_ss = 0;
  logic ctl_clear, ver_ctl, ref_use_pad, utmi_clk_sel, otg_disable, force_suspend, force_sleep;
  logic hs_pwrdn, ss_pwrdn, ret_enable, ref_ss_en, ssc_en, common_on, port_reset, ready, busy;
  logic [5:0] frame_adj;
  logic [4:0] los_level, tx_deemph;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbphy_pwr_seq u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 0; init_req = 0; exit_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_init(input logic m);
    @(negedge clk); init_req = 1; mode_ss = m;
    @(negedge clk); init_req = 0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); exit_req = 1;
    @(negedge clk); exit_req = 0;
  endtask

  // Counts sampled cycles with port_reset high, starting at the current sample.
  task automatic count_hold(output int n);
    n = 0;
    while (port_reset && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rst_high();
    for (int i = 0; i < 20 && !port_reset; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    do_reset();
    // R1 reset state
    chk("R1 frame_adj", frame_adj, 0);
    chk("R1 pad/clksel/ver", {ref_use_pad, utmi_clk_sel, ver_ctl}, 3'b100);
    chk("R1 pwrdn", {hs_pwrdn, ss_pwrdn}, 2'b11);
    chk("R1 enables/rst", {ret_enable, ref_ss_en, ssc_en, common_on, port_reset}, 0);
    chk("R1 misc", {ready, busy, ctl_clear, otg_disable, force_suspend, force_sleep, los_level, tx_deemph}, 0);

    // Step-by-step ordering, high-speed mode
    pulse_init(1'b0);
    @(negedge clk); // after e1
    chk("R3 clear pulse", {ctl_clear, busy}, 2'b11);
    chk("R3 frame untouched", frame_adj, 0);
    @(negedge clk); // after e2
    chk("R3 clear one cycle", ctl_clear, 0);
    chk("R4 frame adj", {ver_ctl, frame_adj}, {1'b1, 6'h20});
    chk("R4 clksrc not yet", {ref_use_pad, utmi_clk_sel}, 2'b10);
    @(negedge clk); // after e3
    chk("R5 clock source", {ref_use_pad, utmi_clk_sel}, 2'b01);
    chk("R5 path not yet", {hs_pwrdn, los_level}, {1'b1, 5'h0});
    @(negedge clk); // after e4
    chk("R6 hs path", {los_level, tx_deemph, otg_disable, force_suspend, force_sleep, hs_pwrdn},
        {5'h09, 5'h1C, 1'b1, 1'b0, 1'b0, 1'b0});
    chk("R6 ss untouched", ss_pwrdn, 1);
    chk("R8 no reset yet", {port_reset, common_on}, 0);
    @(negedge clk); // after e5
    chk("R8 enables with reset", {ret_enable, ref_ss_en, ssc_en, common_on, port_reset}, 5'b11111);
    chk("R9 not ready in reset", ready, 0);
    count_hold(n);
    chk("R8 hold width", n, EXP_HOLD);
    chk("R9 ready at release", {ready, port_reset, busy}, 3'b100);
    chk("R8 only reset drops", {ret_enable, ref_ss_en, ssc_en, common_on}, 4'b1111);

    // Table walk of mode/exit combinations
    do_reset();
    for (int v = 0; v < 5; v++) begin
      if (VEC[v][6]) begin
        pulse_exit();
        @(negedge clk);
        chk("R10 exit force/pwrdn", {otg_disable, force_suspend, force_sleep, hs_pwrdn, ss_pwrdn}, 5'b11111);
        chk("R10 exit enables", {ref_ss_en, ssc_en, common_on, ready, ret_enable}, 5'b00001);
      end
      pulse_init(VEC[v][5]);
      wait_rst_high();
      count_hold(n);
      chk(VEC[v][5] ? "R7 hold width" : "R6 hold width", n, EXP_HOLD);
      chk(VEC[v][5] ? "R7 path fields" : "R6 path fields",
          {los_level, otg_disable, force_suspend, force_sleep, hs_pwrdn, ss_pwrdn},
          {(VEC[v][4] ? 5'h09 : 5'h00), VEC[v][3], VEC[v][2], VEC[v][2], VEC[v][1], VEC[v][0]});
      chk("R5 common fields", {frame_adj, ver_ctl, ref_use_pad, utmi_clk_sel, tx_deemph},
          {6'h20, 1'b1, 1'b0, 1'b1, 5'h1C});
      chk("R9 ready after seq", {ready, port_reset, common_on, ssc_en}, 4'b1011);
    end

    // R2: requests during hold are ignored
    pulse_init(1'b0);
    wait_rst_high();
    repeat (3) @(negedge clk);
    init_req = 1; exit_req = 1;
    @(negedge clk); init_req = 0; exit_req = 0;
    count_hold(n);
    chk("R2 hold not disturbed", n, EXP_HOLD - 4);
    chk("R2 exit ignored", {ready, hs_pwrdn, common_on}, 3'b101);
    repeat (3) @(negedge clk);
    chk("R2 no restart", {busy, port_reset, ctl_clear, ready}, 4'b0001);

    // R11: simultaneous requests -> exit only
    @(negedge clk); init_req = 1; exit_req = 1;
    @(negedge clk); init_req = 0; exit_req = 0;
    chk("R11 no clear strobe", ctl_clear, 0);
    @(negedge clk);
    chk("R11 exit applied", {hs_pwrdn, ss_pwrdn, force_sleep, common_on, ready}, 5'b11100);
    chk("R10 retention kept", ret_enable, 1);
    repeat (4) @(negedge clk);
    chk("R11 no reset given", {busy, port_reset, ctl_clear}, 0);

    finish_run();
  end
endmodule